// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address-Bit Filtering

This block receives asynchronous serial frames on a shared multidrop line. Each frame has a start bit, eight data bits with the least significant bit first, one extra address-marker bit, and a stop bit. The line idles high. The marker bit tells an address (station ID) frame apart from a data frame.

Software can switch on a hardware filter. While the filter is on, every frame whose marker bit is 0 is dropped without a trace. The first marker-1 frame that arrives is delivered, and the filter then switches itself off. Software compares the delivered byte with its own station ID. If the ID matches, it leaves the filter off and collects the data frames that follow. If it does not match, it switches the filter on again and skips traffic meant for other stations.

The input is synchronised first and then oversampled against an external tick. Received bytes land in a holding register with a full flag, a one-cycle interrupt pulse, and sticky flags for a bad stop bit and for a lost byte.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `data_o` is 0, `mpb_o` is 0, `full_o` is 0, `irq_o` is 0, `filt_o` is 0, `frame_err_o` is 0 and `overrun_o` is 0.
- R2: The line is sampled once per tick of `baud_tick_i`, at OVS ticks per bit. A low seen while idle is confirmed as a start bit OVS/2 ticks later. Each later bit is sampled OVS ticks after the one before it. The first data bit received becomes `data_o[0]`.
- R3: A low pulse that is already high again at the mid-start check is ignored. No output changes.
- R4: While `filt_o` is 1, a frame with marker bit 0 is discarded. `data_o` keeps its value, `full_o` does not set, `irq_o` does not pulse, and no error flag changes.
- R5: While `filt_o` is 1, a frame with marker bit 1 and a good stop bit loads `data_o` and sets `mpb_o` to 1. It also sets `full_o`, pulses `irq_o` for one cycle, and clears `filt_o` to 0.
- R6: While `filt_o` is 0, every frame with a good stop bit is delivered, whatever its marker bit. `mpb_o` reports the marker bit of the delivered frame.
- R7: A pulse on `full_clr_i` clears `full_o`. A pulse on `filt_set_i` sets `filt_o` to 1. A pulse on `err_clr_i` clears `frame_err_o` and `overrun_o`.
- R8: A frame that the filter passes but whose stop bit is sampled low sets `frame_err_o`. It leaves `data_o`, `full_o` and `filt_o` unchanged and does not pulse `irq_o`.
- R9: A frame that would be delivered while `full_o` is 1 sets `overrun_o`. `data_o` and `mpb_o` keep their old contents and `irq_o` does not pulse. A marker-1 frame still clears `filt_o` in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input, idles high |
| baud_tick_i | input | 1 | One-cycle tick at OVS times the bit rate |
| filt_set_i | input | 1 | Sets the address filter enable |
| full_clr_i | input | 1 | Clears the full flag after a read |
| err_clr_i | input | 1 | Clears the framing and overrun flags |
| data_o | output | DATA_W | Last delivered byte |
| mpb_o | output | 1 | Marker bit of the last delivered frame |
| full_o | output | 1 | Holding register contains an unread byte |
| irq_o | output | 1 | One-cycle pulse when a byte is delivered |
| filt_o | output | 1 | Address filter enable |
| frame_err_o | output | 1 | Sticky flag: stop bit sampled low |
| overrun_o | output | 1 | Sticky flag: frame lost because the register was full |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and OVS = 16. It drives a tick every fourth clock and changes the line only between ticks. This makes the mid-start check land exactly on the ninth tick of the start bit. A three-tick glitch is therefore rejected, and the half stop bit left after a framing error cannot start a phantom frame. With an eight-bit byte and the default oversampling, random marker bits, filter re-arming, skipped clears and bad stop bits all combine in a short run. That covers filter self-clearing, overrun while the filter is on, and errors on frames the filter rejects.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_st_e;

  // frame passes the address filter
  function automatic logic mpr_pass(input logic filt, input logic mpb);
    return !filt || mpb;
  endfunction
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mpr_sampler.sv
module mpr_sampler
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  output logic              frm_v_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic              frm_mpb_o,
  output logic              frm_stop_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int NBITS = DATA_W + 2;          // data, marker, stop
  localparam int IDX_W = $clog2(NBITS);

  rx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W:0]   sh_q;
  logic              v_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      v_q    <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      v_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx_i) begin
              st_q  <= ST_START;
              cnt_q <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_W'(HALF - 1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rx_i ? ST_IDLE : ST_BITS;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BITS: begin
            if (cnt_q == CNT_W'(OVS - 1)) begin
              cnt_q <= '0;
              if (idx_q == IDX_W'(NBITS - 1)) begin
                v_q    <= 1'b1;
                stop_q <= rx_i;
                st_q   <= ST_IDLE;
              end else begin
                sh_q  <= {rx_i, sh_q[DATA_W:1]};   // LSB first
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign frm_v_o    = v_q;
  assign frm_data_o = sh_q[DATA_W-1:0];
  assign frm_mpb_o  = sh_q[DATA_W];
  assign frm_stop_o = stop_q;
endmodule

// File: rtl/mpr_regs.sv
module mpr_regs
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_v_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_mpb_i,
  input  logic              frm_stop_i,
  input  logic              filt_set_i,
  input  logic              full_clr_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              filt_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  logic pass, good, busy, load;

  assign pass = frm_v_i && mpr_pass(filt_o, frm_mpb_i);
  assign good = pass && frm_stop_i;
  assign busy = full_o && !full_clr_i;        // a same-cycle clear frees the register
  assign load = good && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mpb_o  <= 1'b0;
      full_o <= 1'b0;
      irq_o  <= 1'b0;
      filt_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      irq_o <= load;
      if (load) begin
        data_o <= frm_data_i;
        mpb_o  <= frm_mpb_i;
      end
      if (load)            full_o <= 1'b1;
      else if (full_clr_i) full_o <= 1'b0;

      if (filt_set_i)                filt_o <= 1'b1;
      else if (good && frm_mpb_i)    filt_o <= 1'b0;

      if (pass && !frm_stop_i) ferr_o <= 1'b1;
      else if (err_clr_i)      ferr_o <= 1'b0;

      if (good && busy)        ovr_o <= 1'b1;
      else if (err_clr_i)      ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic              filt_set_i,
  input  logic              full_clr_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              filt_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              rx_s;
  logic              frm_v, frm_mpb, frm_stop;
  logic [DATA_W-1:0] frm_data;

  mpr_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  mpr_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .tick_i    (baud_tick_i),
    .frm_v_o   (frm_v),
    .frm_data_o(frm_data),
    .frm_mpb_o (frm_mpb),
    .frm_stop_o(frm_stop)
  );

  mpr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frm_v_i   (frm_v),
    .frm_data_i(frm_data),
    .frm_mpb_i (frm_mpb),
    .frm_stop_i(frm_stop),
    .filt_set_i(filt_set_i),
    .full_clr_i(full_clr_i),
    .err_clr_i (err_clr_i),
    .data_o    (data_o),
    .mpb_o     (mpb_o),
    .full_o    (full_o),
    .irq_o     (irq_o),
    .filt_o    (filt_o),
    .ferr_o    (frame_err_o),
    .ovr_o     (overrun_o)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_v,
  input logic              frm_mpb,
  input logic              frm_stop,
  input logic              filt_set_i,
  input logic              full_clr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              irq_o,
  input logic              filt_o,
  input logic              frame_err_o,
  input logic              overrun_o
);
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_o && frm_v && !frm_mpb |=> !irq_o && $stable(data_o));

  p_id_clears_filt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_o && frm_v && frm_mpb && frm_stop && !filt_set_i |=> !filt_o);

  p_irq_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o);

  p_full_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_clr_i && !frm_v |=> !full_o);

  p_ferr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_v && !frm_stop && (!filt_o || frm_mpb) |=> frame_err_o && !irq_o && $stable(data_o));

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_v && frm_stop && (!filt_o || frm_mpb) && full_o && !full_clr_i
    |=> overrun_o && $stable(data_o) && !irq_o);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frm_v      (frm_v),
  .frm_mpb    (frm_mpb),
  .frm_stop   (frm_stop),
  .filt_set_i (filt_set_i),
  .full_clr_i (full_clr_i),
  .data_o     (data_o),
  .full_o     (full_o),
  .irq_o      (irq_o),
  .filt_o     (filt_o),
  .frame_err_o(frame_err_o),
  .overrun_o  (overrun_o)
);

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
  localparam int DW  = 8;
  localparam int OVS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, filt_set = 1'b0, full_clr = 1'b0, err_clr = 1'b0;
  logic [DW-1:0] data;
  logic mpb, full, irq, filt, ferr, ovr;

  always #5 clk = ~clk;

  mp_uart_rx #(.DATA_W(DW), .OVS(OVS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .baud_tick_i(tick),
    .filt_set_i(filt_set), .full_clr_i(full_clr), .err_clr_i(err_clr),
    .data_o(data), .mpb_o(mpb), .full_o(full), .irq_o(irq), .filt_o(filt),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  int n_tests = 0, n_fail = 0, irq_cnt = 0, exp_irq = 0;
  logic [DW-1:0] m_data = '0;
  logic m_mpb = 0, m_full = 0, m_filt = 0, m_ferr = 0, m_ovr = 0;

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  function automatic logic passes(input logic f, input logic b);
    return !f || b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " data"},  32'(data), 32'(m_data));
    chk({req, " mpb"},   32'(mpb),  32'(m_mpb));
    chk({req, " full"},  32'(full), 32'(m_full));
    chk({req, " filt"},  32'(filt), 32'(m_filt));
    chk({req, " ferr"},  32'(ferr), 32'(m_ferr));
    chk({req, " ovr"},   32'(ovr),  32'(m_ovr));
    chk({req, " irqs"},  32'(irq_cnt), 32'(exp_irq));
  endtask

  task automatic one_tick();
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    for (int t = 0; t < OVS; t++) one_tick();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: begin full_clr = 1'b1; m_full = 1'b0; end
      1: begin filt_set = 1'b1; m_filt = 1'b1; end
      default: begin err_clr = 1'b1; m_ferr = 1'b0; m_ovr = 1'b0; end
    endcase
    @(negedge clk);
    full_clr = 1'b0; filt_set = 1'b0; err_clr = 1'b0;
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic b, input logic stop);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    send_bit(b);
    send_bit(stop);
    send_bit(1'b1);
    send_bit(1'b1);
    if (passes(m_filt, b)) begin
      if (!stop) m_ferr = 1'b1;
      else begin
        if (b) m_filt = 1'b0;
        if (m_full) m_ovr = 1'b1;
        else begin
          m_data = d; m_mpb = b; m_full = 1'b1; exp_irq++;
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    send_bit(1'b1);
    check_all("R1");

    // R6 / R2: filter off, plain reception, LSB first
    send_frame(8'hA5, 1'b0, 1'b1);
    check_all("R6 R2");
    pulse(0);
    send_frame(8'h3C, 1'b1, 1'b1);
    check_all("R6");
    pulse(0);

    // R3: short glitch rejected
    rxd = 1'b0;
    repeat (3) one_tick();
    send_bit(1'b1);
    send_bit(1'b1);
    check_all("R3");

    // R4 / R5: filter drops data, accepts ID and clears itself
    pulse(1);
    check_all("R7");
    send_frame(8'h11, 1'b0, 1'b1);
    check_all("R4");
    send_frame(8'h42, 1'b1, 1'b1);
    check_all("R5");
    chk("R5 filt cleared", 32'(filt), 32'd0);

    // R9: overrun keeps old data
    send_frame(8'h99, 1'b0, 1'b1);
    check_all("R9");
    chk("R9 ovr", 32'(ovr), 32'd1);

    // R7: clears
    pulse(0);
    pulse(2);
    check_all("R7");

    // R8: bad stop bit
    send_frame(8'hF0, 1'b0, 1'b0);
    check_all("R8");
    chk("R8 ferr", 32'(ferr), 32'd1);
    pulse(2);

    // R8 / R4: bad stop while filtering a data frame is silent
    pulse(1);
    send_frame(8'h0F, 1'b0, 1'b0);
    check_all("R4 R8");

    // random mix
    for (int k = 0; k < 50; k++) begin
      if ($urandom % 3 != 0) pulse(0);
      if ($urandom % 4 == 0) pulse(1);
      if ($urandom % 6 == 0) pulse(2);
      send_frame(8'($urandom), 1'($urandom), ($urandom % 8) != 0);
      check_all("R2 R4 R5 R6 R8 R9 rnd");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule